// File: doc/BRIEF.md
# Two-Way Virtually Indexed, Physically Tagged Data Cache

This block is a write-back, write-allocate data cache with two ways per set. The set index and word select come from the low bits of the virtual address, which do not change under translation. The set can therefore be read while an external translator turns the virtual page into a physical page number in the same cycle. Each way's stored tag is then compared against the translated page number, together with the page-offset bit above the index.

A hit is served in the cycle it is presented. A miss, or a translation that is not yet available, holds the request back. On a miss the cache first writes out a dirty victim and then refills the line, one word per memory handshake, before it accepts the request.

The CPU request channel is valid/ready. The CPU raises `cpu_req_valid` and keeps the address, write flag, write data and translation inputs stable until it sees `cpu_req_ready` high at a rising edge. The request is accepted on that edge. The cache never drops an offered request.

The memory channel is also valid/ready, with one word per beat. `mem_req_valid` together with the address, write flag and write data hold stable until `mem_req_ready` is high at a rising edge. On read beats the memory presents `mem_rsp_rdata` in that same cycle.

Top module: `vipt_cache`

## Requirements
- R1: The set is selected by virtual address bits [10:4] and the word within the 16-byte line by bits [3:2]. Virtual address bits [31:12] have no effect on hit, miss or data.
- R2: A request hits only when `xlat_hit` is high and one valid way holds the tag {`xlat_ppn`, vaddr[11]}. A hit is accepted (`cpu_req_ready` high) in the cycle it is first presented, and `cpu_rsp_valid` is high one cycle after acceptance.
- R3: While `xlat_hit` is low, `cpu_req_ready` stays low, no memory beat is issued and no line is allocated.
- R4: A read returns the most recent value written by the CPU to that physical word, or the memory content if it was never written, including after the line was evicted and refetched. For a write, `cpu_rsp_rdata` echoes the written data.
- R5: A write hit causes no memory traffic. A dirty line is written to memory only when it is evicted.
- R6: A write miss fetches the line, then performs the write. A later read of the line hits.
- R7: The victim in a set is the way not accessed most recently, tracked by one bit per set.
- R8: A miss whose victim is dirty issues four write beats to the victim's address, words 0 to 3 in order, followed by four read beats at the new line address, words 0 to 3 in order. A miss with a clean victim issues only the four read beats.
- R9: `cpu_req_ready` stays low for the whole of any eviction or refill.
- R10: Reset clears all valid, dirty and replacement bits. After reset a previously cached line misses, and a previously dirty line is dropped without a write-back.
- R11: A memory beat completes only on a cycle with `mem_req_ready` high. Its address, write flag and write data stay stable until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU offers a request |
| cpu_req_ready | output | 1 | Request accepted at this edge |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_vaddr | input | 32 | Virtual byte address, word aligned |
| cpu_req_wdata | input | 32 | Write data |
| xlat_ppn | input | 20 | Physical page number from the translator |
| xlat_hit | input | 1 | Translator has a valid mapping |
| cpu_rsp_valid | output | 1 | Response for the request accepted last cycle |
| cpu_rsp_rdata | output | 32 | Read data, or echoed write data |
| mem_req_valid | output | 1 | Memory beat offered |
| mem_req_ready | input | 1 | Memory completes the beat at this edge |
| mem_req_write | output | 1 | 1 = write beat (eviction), 0 = read beat (refill) |
| mem_req_addr | output | 32 | Physical byte address of the beat |
| mem_req_wdata | output | 32 | Eviction data |
| mem_rsp_rdata | input | 32 | Refill data, valid with `mem_req_ready` on read beats |

## Verification
A hit must show `cpu_req_ready` in the very cycle it is first presented. The response then appears one edge later. The bench presents each request just after a falling edge, samples ready a quarter period later, and reads `cpu_rsp_valid` and the data at the falling edge after the accepting edge.

Misses take a number of cycles that depends on the memory model. For these the bench does not count cycles: it counts and logs the memory beats it granted and compares them with the expected 0, 4 or 8 beats and their order. The bench memory grants every other cycle, so a beat held without ready is exercised on every transfer.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } miss_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
  import vipt_cache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 21
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   lk_set,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic [NUM_WAYS-1:0]       hit_way,
  output logic                      vic_way,
  output logic                      vic_dirty,
  output logic [TAG_W-1:0]          vic_tag,
  input  logic                      touch_en,
  input  logic                      touch_way,
  input  logic                      touch_write,
  input  logic                      fill_en,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic                      fill_way,
  input  logic [TAG_W-1:0]          fill_tag
);
  logic [TAG_W-1:0] tag_q   [NUM_WAYS][SETS];
  logic [SETS-1:0]  valid_q [NUM_WAYS];
  logic [SETS-1:0]  dirty_q [NUM_WAYS];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_way[w] = valid_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);

    // A line may only be dirty while it is valid.
    assert_dirty_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[w][lk_set] |-> valid_q[w][lk_set]);
  end

  assign vic_way   = lru_q[lk_set];
  assign vic_dirty = valid_q[vic_way][lk_set] && dirty_q[vic_way][lk_set];
  assign vic_tag   = tag_q[vic_way][lk_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
      lru_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (fill_en && fill_way == 1'(w)) begin
          valid_q[w][fill_set] <= 1'b1;
          dirty_q[w][fill_set] <= 1'b0;
        end else if (touch_en && touch_write && touch_way == 1'(w)) begin
          dirty_q[w][lk_set] <= 1'b1;
        end
      end
      if (touch_en) lru_q[lk_set] <= ~touch_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_way][fill_set] <= fill_tag;
  end

  // At most one way may match a given tag.
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way));
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
  import vipt_cache_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic [$clog2(SETS)-1:0]    rd_set,
  input  logic                       rd_way,
  input  logic [$clog2(WORDS)-1:0]   rd_word,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wr_en,
  input  logic [$clog2(SETS)-1:0]    wr_set,
  input  logic                       wr_way,
  input  logic [$clog2(WORDS)-1:0]   wr_word,
  input  logic [DATA_W-1:0]          wr_data
);
  logic [DATA_W-1:0] line_q [NUM_WAYS][SETS][WORDS];

  assign rd_data = line_q[rd_way][rd_set][rd_word];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_way][wr_set][wr_word] <= wr_data;
  end
endmodule

// File: rtl/vipt_miss_ctrl.sv
module vipt_miss_ctrl
  import vipt_cache_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_start,
  input  logic                       need_evict,
  input  logic                       mem_ready,
  output miss_state_e                state,
  output logic [$clog2(WORDS)-1:0]   beat,
  output logic                       fill_last
);
  localparam int WOFF_W = $clog2(WORDS);
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WORDS - 1);

  assign fill_last = (state == ST_REFILL) && mem_ready && (beat == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOOKUP;
      beat  <= '0;
    end else begin
      unique case (state)
        ST_LOOKUP: begin
          beat <= '0;
          if (miss_start) state <= need_evict ? ST_EVICT : ST_REFILL;
        end
        ST_EVICT: if (mem_ready) begin
          beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
          if (beat == LAST_BEAT) state <= ST_REFILL;
        end
        ST_REFILL: if (mem_ready) begin
          beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
          if (beat == LAST_BEAT) state <= ST_LOOKUP;
        end
        default: state <= ST_LOOKUP;
      endcase
    end
  end

  // The word counter moves only when memory completes a beat.
  assert_beat_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LOOKUP && !mem_ready) |=> $stable(beat));

  // An eviction always hands over to a refill, never straight back to lookup.
  assert_evict_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVICT) |=> (state != ST_LOOKUP));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int SETS       = 128,
  parameter int WORDS      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req_valid,
  output logic                         cpu_req_ready,
  input  logic                         cpu_req_write,
  input  logic [ADDR_W-1:0]            cpu_req_vaddr,
  input  logic [DATA_W-1:0]            cpu_req_wdata,
  input  logic [ADDR_W-PAGE_OFF_W-1:0] xlat_ppn,
  input  logic                         xlat_hit,
  output logic                         cpu_rsp_valid,
  output logic [DATA_W-1:0]            cpu_rsp_rdata,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_write,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [DATA_W-1:0]            mem_req_wdata,
  input  logic [DATA_W-1:0]            mem_rsp_rdata
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int BOFF_W = WOFF_W + BYTE_W;
  localparam int LOW_W  = BOFF_W + IDX_W;
  localparam int TAG_W  = ADDR_W - LOW_W;

  // Lookup side: set and word from untranslated bits, tag from the translated address.
  logic [ADDR_W-1:0] phys_addr;
  logic [IDX_W-1:0]  lk_set;
  logic [WOFF_W-1:0] lk_word;
  logic [TAG_W-1:0]  lk_tag;
  logic              unused_addr_bits;

  assign phys_addr = {xlat_ppn, cpu_req_vaddr[PAGE_OFF_W-1:0]};
  assign lk_set    = cpu_req_vaddr[BOFF_W +: IDX_W];
  assign lk_word   = cpu_req_vaddr[BYTE_W +: WOFF_W];
  assign lk_tag    = phys_addr[ADDR_W-1 -: TAG_W];
  assign unused_addr_bits = ^{cpu_req_vaddr[ADDR_W-1:PAGE_OFF_W], phys_addr[LOW_W-1:0]};

  miss_state_e       state;
  logic [WOFF_W-1:0] beat;
  logic              fill_last;
  logic              in_lookup;
  logic [NUM_WAYS-1:0] hit_way;
  logic              hit_any, hit_idx;
  logic              vic_way, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic              accept, miss_start;

  assign in_lookup  = (state == ST_LOOKUP);
  assign hit_any    = |hit_way;
  assign hit_idx    = hit_way[1];
  assign accept     = in_lookup && cpu_req_valid && xlat_hit && hit_any;
  assign miss_start = in_lookup && cpu_req_valid && xlat_hit && !hit_any;
  assign cpu_req_ready = accept;

  // Miss context captured when the miss is detected.
  logic [IDX_W-1:0] m_set;
  logic             m_way;
  logic [TAG_W-1:0] m_new_tag;
  logic [TAG_W-1:0] m_old_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_set     <= '0;
      m_way     <= 1'b0;
      m_new_tag <= '0;
      m_old_tag <= '0;
    end else if (miss_start) begin
      m_set     <= lk_set;
      m_way     <= vic_way;
      m_new_tag <= lk_tag;
      m_old_tag <= vic_tag;
    end
  end

  vipt_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_set      (lk_set),
    .lk_tag      (lk_tag),
    .hit_way     (hit_way),
    .vic_way     (vic_way),
    .vic_dirty   (vic_dirty),
    .vic_tag     (vic_tag),
    .touch_en    (accept),
    .touch_way   (hit_idx),
    .touch_write (cpu_req_write),
    .fill_en     (fill_last),
    .fill_set    (m_set),
    .fill_way    (m_way),
    .fill_tag    (m_new_tag)
  );

  vipt_miss_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_start (miss_start),
    .need_evict (vic_dirty),
    .mem_ready  (mem_req_ready),
    .state      (state),
    .beat       (beat),
    .fill_last  (fill_last)
  );

  // Data array: one read port shared by hits and eviction, one write port.
  logic [IDX_W-1:0]  rd_set, wr_set;
  logic              rd_way, wr_way, wr_en;
  logic [WOFF_W-1:0] rd_word, wr_word;
  logic [DATA_W-1:0] rd_data, wr_data;

  always_comb begin
    if (in_lookup) begin
      rd_set = lk_set; rd_way = hit_idx; rd_word = lk_word;
    end else begin
      rd_set = m_set;  rd_way = m_way;   rd_word = beat;
    end
    if (state == ST_REFILL) begin
      wr_en   = mem_req_ready;
      wr_set  = m_set; wr_way = m_way; wr_word = beat;
      wr_data = mem_rsp_rdata;
    end else begin
      wr_en   = accept && cpu_req_write;
      wr_set  = lk_set; wr_way = hit_idx; wr_word = lk_word;
      wr_data = cpu_req_wdata;
    end
  end

  vipt_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_set  (rd_set),
    .rd_way  (rd_way),
    .rd_word (rd_word),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_set  (wr_set),
    .wr_way  (wr_way),
    .wr_word (wr_word),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= accept;
      if (accept) cpu_rsp_rdata <= cpu_req_write ? cpu_req_wdata : rd_data;
    end
  end

  assign mem_req_valid = !in_lookup;
  assign mem_req_write = (state == ST_EVICT);
  assign mem_req_addr  = {(state == ST_EVICT) ? m_old_tag : m_new_tag, m_set, beat,
                          {BYTE_W{1'b0}}};
  assign mem_req_wdata = rd_data;

  // The CPU side stays stalled while the line is being moved.
  assert_stall_in_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LOOKUP) |-> !cpu_req_ready);

  // Without a translation nothing is started.
  assert_xlat_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lookup && cpu_req_valid && !xlat_hit) |=> (state == ST_LOOKUP && !mem_req_valid));

  // A pending memory beat holds its fields until memory takes it.
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

  // Every accepted request is answered on the next cycle.
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> cpu_rsp_valid);
endmodule

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [31:0] cpu_req_vaddr, cpu_req_wdata;
  logic [19:0] xlat_ppn;
  logic        xlat_hit;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_vaddr(cpu_req_vaddr),
    .cpu_req_wdata(cpu_req_wdata), .xlat_ppn(xlat_ppn), .xlat_hit(xlat_hit),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Fields: write, vaddr, wdata, ppn, expected memory beats.
  localparam logic [88:0] VECS [NVEC] = '{
    {1'b0, 32'h0000_0030, 32'h0,           20'h00011, 4'd4},
    {1'b0, 32'hABCD_0034, 32'h0,           20'h00011, 4'd0},
    {1'b1, 32'h0000_0038, 32'hDEAD_0001,   20'h00011, 4'd0},
    {1'b0, 32'h1234_5038, 32'h0,           20'h00011, 4'd0},
    {1'b0, 32'h0000_0030, 32'h0,           20'h00022, 4'd4},
    {1'b0, 32'h0000_0030, 32'h0,           20'h00033, 4'd8},
    {1'b0, 32'h0000_0038, 32'h0,           20'h00011, 4'd4},
    {1'b1, 32'h0000_0054, 32'hBEEF_0002,   20'h00044, 4'd4},
    {1'b0, 32'h0000_0054, 32'h0,           20'h00044, 4'd0},
    {1'b0, 32'h0000_0858, 32'h0,           20'h00044, 4'd4},
    {1'b0, 32'h0000_0054, 32'h0,           20'h00044, 4'd0},
    {1'b0, 32'h0000_0054, 32'h0,           20'h00055, 4'd4},
    {1'b0, 32'h0000_0858, 32'h0,           20'h00044, 4'd8},
    {1'b0, 32'h0000_0054, 32'h0,           20'h00044, 4'd4},
    {1'b1, 32'h0000_0850, 32'hCAFE_0003,   20'h00044, 4'd0}
  };

  function automatic string vec_req(int i);
    case (i)
      1, 3:          return "R1";
      9:             return "R2";
      0, 6, 13:      return "R4";
      2, 5, 14:      return "R5";
      7, 8:          return "R6";
      default:       return "R7";
    endcase
  endfunction

  logic [31:0] mem_store [logic [31:0]];
  logic [31:0] gold      [logic [31:0]];
  logic [31:0] log_addr  [16];
  logic        log_we    [16];
  int          log_n = 0;

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] gold_rd(logic [31:0] a);
    return gold.exists(a) ? gold[a] : pat(a);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Memory model: grants a pending beat at the falling edge after it appears.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && !mem_req_ready) begin
        mem_req_ready = 1'b1;
        if (mem_req_write) mem_store[mem_req_addr] = mem_req_wdata;
        else mem_rsp_rdata = mem_store.exists(mem_req_addr) ? mem_store[mem_req_addr]
                                                            : pat(mem_req_addr);
        if (log_n < 16) begin
          log_addr[log_n] = mem_req_addr;
          log_we[log_n]   = mem_req_write;
        end
        log_n++;
      end else begin
        mem_req_ready = 1'b0;
      end
    end
  end

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
    cpu_req_vaddr = '0; cpu_req_wdata = '0; xlat_ppn = '0; xlat_hit = 1'b0;
    repeat (3) @(negedge clk);
    check(!cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R10",
          "outputs idle in reset", {29'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic run_access(input logic we, input logic [31:0] va, input logic [31:0] wd,
                            input logic [19:0] ppn, input int exp_beats, input int stall,
                            input string rq);
    logic [31:0] pa, exp_d;
    int cyc;
    bit acc, overlap, ord_ok;
    pa = {ppn, va[11:0]};
    exp_d = we ? wd : gold_rd(pa);
    @(negedge clk);
    log_n = 0;
    cpu_req_valid = 1'b1; cpu_req_write = we; cpu_req_vaddr = va; cpu_req_wdata = wd;
    xlat_ppn = (stall > 0) ? 20'hFFFFF : ppn;
    xlat_hit = (stall == 0);
    for (int s = 0; s < stall; s++) begin
      #(CLK_PERIOD/4);
      check(!cpu_req_ready && !mem_req_valid, "R3", "stall while translation misses",
            {30'd0, cpu_req_ready, mem_req_valid}, 32'd0);
      @(negedge clk);
    end
    xlat_ppn = ppn; xlat_hit = 1'b1;
    cyc = 0; acc = 0; overlap = 0;
    while (!acc && cyc < 400) begin
      #(CLK_PERIOD/4);
      if (cpu_req_ready && mem_req_valid) overlap = 1;
      if (cpu_req_ready) acc = 1; else cyc++;
      @(negedge clk);
    end
    cpu_req_valid = 1'b0;
    check(acc, "R2", "request accepted", 32'(acc), 32'd1);
    if (exp_beats == 0)
      check(cyc == 0, "R2", "hit accepted in first cycle", 32'(cyc), 32'd0);
    check(!overlap, "R9", "ready low during line transfer", 32'(overlap), 32'd0);
    check(cpu_rsp_valid && cpu_rsp_rdata == exp_d, rq, "response data",
          cpu_rsp_rdata, exp_d);
    check(log_n == exp_beats, rq, "memory beat count", 32'(log_n), 32'(exp_beats));
    ord_ok = 1;
    for (int i = 0; i < log_n && i < 16; i++) begin
      if (log_we[i] != (exp_beats == 8 && i < 4)) ord_ok = 0;
      if (log_addr[i][3:0] != {2'(i % 4), 2'b00}) ord_ok = 0;
      if (log_addr[i][10:4] != va[10:4]) ord_ok = 0;
      if (!log_we[i] && log_addr[i][31:11] != {ppn, va[11]}) ord_ok = 0;
    end
    check(ord_ok, "R8 R11", "beat order and addresses", 32'(ord_ok), 32'd1);
    if (we) gold[pa] = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    apply_reset();
    for (int i = 0; i < NVEC; i++) begin
      run_access(VECS[i][88], VECS[i][87:56], VECS[i][55:24], VECS[i][23:4],
                 int'(VECS[i][3:0]), 0, vec_req(i));
    end

    // R3: translation miss holds the request, then a clean line fill follows.
    run_access(1'b0, 32'h0000_0120, 32'h0, 20'h00066, 4, 5, "R3");
    run_access(1'b0, 32'h0000_0124, 32'h0, 20'h00066, 0, 0, "R3");

    // R10: the line written last is dirty; reset drops it without a write-back.
    apply_reset();
    void'(gold.delete(32'h0004_4850));
    run_access(1'b0, 32'h0000_0850, 32'h0, 20'h00044, 4, 0, "R10");
    run_access(1'b0, 32'h0000_0030, 32'h0, 20'h00033, 4, 0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule